// File: doc/BRIEF.md
# H-Bridge Command Decode and Fault Latch

This block is the digital control core of a motor driver that has two half-bridge legs. It takes a level command for each leg, a global invert select, and two disable controls of opposite polarity: a halt input that disables when high, and an arm input that disables when low. It also takes a wake input and comparator outputs for undervoltage, overtemperature, a cool-down indication and short circuit. From these it produces a high-side and a low-side gate enable for each leg, and an active-low status flag. Every asynchronous input passes through a two-flop synchronizer before any decision is made.

A state machine with five states decides whether the bridge may drive. The states are ST_SLEEP (wake low), ST_OFF (halt high or arm low), ST_DRIVE (the legs follow their commands), ST_UV (undervoltage, clears by itself) and ST_LATCH (short circuit or overtemperature, held until cleared).

- From any awake state, wake low leads to ST_SLEEP.
- An awake state, or ST_SLEEP once wake rises, moves to the state that current conditions select. The order of priority is latch, then UV, then OFF, then DRIVE.
- ST_LATCH is left in two ways. Wake going low leads to ST_SLEEP. A clearing edge, taken while cool is high, leads to the state that current conditions select.

Each leg has its own dead-band unit. It turns the drive decision into gate enables and never lets both switches of one leg conduct together.

Top module: `hbridge_ctrl`

## Requirements
- R1: With invert low and the bridge driving, a leg command of 1 gives high-side on and low-side off for that leg, and a command of 0 gives low-side on and high-side off. Each leg follows only its own command.
- R2: With invert high, both leg commands are low-true: a command of 0 turns the high side on and a command of 1 turns the low side on.
- R3: If halt is 1 or arm is 0, all four gate enables are 0 and the status flag stays high.
- R4: If wake is 0, the block sleeps: all four gate enables are 0 and the flag is high, whatever the other inputs are.
- R5: During reset and just after it, all four gate enables are 0 and flag_n_o is 1.
- R6: A short-circuit indication latches a fault. While the fault is latched, all gates are off and flag_n_o is 0. This holds after the indication goes away and regardless of changes to the leg commands.
- R7: A latched fault is cleared by a 1-to-0 change of halt or by a 0-to-1 change of arm. A change in the opposite direction does not clear it.
- R8: Taking wake low clears a latched fault. When wake returns high, the bridge resumes normal operation.
- R9: An overtemperature indication latches like a short circuit. A clearing edge takes effect only while cool_i is 1, and an edge seen while cool_i is 0 is discarded.
- R10: Undervoltage turns all gates off and drives flag_n_o low. When undervoltage goes away, the previous drive state and a high flag return without any clearing edge.
- R11: The high-side and low-side enables of one leg are never both 1. Each handover from one side to the other leaves both sides off for exactly DEAD_CYC clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| leg_a_i | input | 1 | Level command for leg A (idle value 1) |
| leg_b_i | input | 1 | Level command for leg B (idle value 1) |
| invert_i | input | 1 | Makes both leg commands low-true when 1 |
| halt_i | input | 1 | Disables the bridge when 1 (idle value 1) |
| arm_i | input | 1 | Disables the bridge when 0 (idle value 0) |
| wake_i | input | 1 | Sleep when 0 |
| uv_i | input | 1 | Undervoltage comparator |
| ot_i | input | 1 | Overtemperature trip comparator |
| cool_i | input | 1 | Temperature is below trip minus hysteresis |
| sc_i | input | 1 | Short-circuit comparator |
| hs_a_o | output | 1 | Leg A high-side enable |
| ls_a_o | output | 1 | Leg A low-side enable |
| hs_b_o | output | 1 | Leg B high-side enable |
| ls_b_o | output | 1 | Leg B low-side enable |
| flag_n_o | output | 1 | Status flag, low on fault or undervoltage |

## Verification
The bench builds the block with DEAD_CYC set to 2. At that setting a full handover, including synchronizer and state latency, settles within a dozen cycles. This allows a sweep over all 64 combinations of the six control inputs, each checked against the steady outputs computed from the decode rules. With a short dead band, the off window on a leg can be counted cycle by cycle in both directions of handover. The bench then runs each fault path: latch, the wrong edge direction, the right edge, clearing by wake, a clear blocked while hot, and undervoltage recovery.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_OFF,
        ST_DRIVE,
        ST_UV,
        ST_LATCH
    } hb_state_e;

    typedef struct packed {
        logic leg_a;
        logic leg_b;
        logic invert;
        logic halt;
        logic arm;
        logic wake;
        logic uv;
        logic ot;
        logic cool;
        logic sc;
    } hb_in_t;

    localparam int IN_W = $bits(hb_in_t);

    localparam hb_in_t IN_IDLE = '{
        leg_a:  1'b1,
        leg_b:  1'b1,
        invert: 1'b0,
        halt:   1'b1,
        arm:    1'b0,
        wake:   1'b0,
        uv:     1'b0,
        ot:     1'b0,
        cool:   1'b1,
        sc:     1'b0
    };

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int               W       = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end

endmodule

// File: rtl/hb_ctrl_fsm.sv
module hb_ctrl_fsm
    import hb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  hb_in_t s_i,
    output logic   drive_en_o,
    output logic   flag_n_o
);

    hb_state_e st_q, st_d;
    logic      halt_q, arm_q;
    logic      clr_ev;

    function automatic hb_state_e pick(input hb_in_t v);
        if (v.sc || v.ot)           return ST_LATCH;
        else if (v.uv)              return ST_UV;
        else if (v.halt || !v.arm)  return ST_OFF;
        else                        return ST_DRIVE;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_q <= IN_IDLE.halt;
            arm_q  <= IN_IDLE.arm;
        end else begin
            halt_q <= s_i.halt;
            arm_q  <= s_i.arm;
        end
    end

    assign clr_ev = ((halt_q && !s_i.halt) || (!arm_q && s_i.arm)) && s_i.cool;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_SLEEP: if (s_i.wake) st_d = pick(s_i);
            ST_OFF,
            ST_DRIVE,
            ST_UV:    st_d = s_i.wake ? pick(s_i) : ST_SLEEP;
            ST_LATCH: begin
                if (!s_i.wake)   st_d = ST_SLEEP;
                else if (clr_ev) st_d = pick(s_i);
            end
            default:  st_d = ST_SLEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_SLEEP;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_n_o <= 1'b1;
        else        flag_n_o <= !(st_d == ST_UV || st_d == ST_LATCH);
    end

    assign drive_en_o = (st_q == ST_DRIVE);

    p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LATCH && s_i.wake && !clr_ev) |=> st_q == ST_LATCH);

    p_flag_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LATCH || st_q == ST_UV) |-> !flag_n_o);

    p_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !s_i.wake |=> (st_q == ST_SLEEP && !drive_en_o));

    p_hot_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LATCH && !s_i.cool) |=> (st_q == ST_LATCH || st_q == ST_SLEEP));

    p_uv_recover_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_UV && s_i.wake && !s_i.uv && !s_i.sc && !s_i.ot) |=> (st_q != ST_UV && flag_n_o));

endmodule

// File: rtl/hb_deadband.sv
module hb_deadband #(
    parameter int DEAD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_en_i,
    input  logic level_i,
    output logic hs_o,
    output logic ls_o
);

    localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC);
    localparam logic [CW-1:0] LOAD = CW'(DEAD_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          hs_t, ls_t;

    assign hs_t = drive_en_i &&  level_i;
    assign ls_t = drive_en_i && !level_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_o  <= 1'b0;
            ls_o  <= 1'b0;
            cnt_q <= '0;
        end else if ((hs_o || ls_o) && (hs_o != hs_t || ls_o != ls_t)) begin
            hs_o  <= 1'b0;
            ls_o  <= 1'b0;
            cnt_q <= LOAD;
        end else if (!hs_o && !ls_o) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else begin
                hs_o <= hs_t;
                ls_o <= ls_t;
            end
        end
    end

    p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_o && ls_o));

    p_hs_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_o) |-> !ls_o);

    p_ls_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ls_o) |-> !hs_o);

endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
    import hb_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic leg_a_i,
    input  logic leg_b_i,
    input  logic invert_i,
    input  logic halt_i,
    input  logic arm_i,
    input  logic wake_i,
    input  logic uv_i,
    input  logic ot_i,
    input  logic cool_i,
    input  logic sc_i,
    output logic hs_a_o,
    output logic ls_a_o,
    output logic hs_b_o,
    output logic ls_b_o,
    output logic flag_n_o
);

    localparam int LEGS = 2;

    hb_in_t          raw, syn;
    logic            drive_en;
    logic [LEGS-1:0] cmd, hs, ls;

    assign raw = '{
        leg_a:  leg_a_i,
        leg_b:  leg_b_i,
        invert: invert_i,
        halt:   halt_i,
        arm:    arm_i,
        wake:   wake_i,
        uv:     uv_i,
        ot:     ot_i,
        cool:   cool_i,
        sc:     sc_i
    };

    hb_sync #(
        .W       (IN_W),
        .RST_VAL (IN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (syn)
    );

    hb_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_i        (syn),
        .drive_en_o (drive_en),
        .flag_n_o   (flag_n_o)
    );

    assign cmd = {syn.leg_b, syn.leg_a};

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        hb_deadband #(
            .DEAD_CYC (DEAD_CYC)
        ) u_db (
            .clk        (clk),
            .rst_n      (rst_n),
            .drive_en_i (drive_en),
            .level_i    (cmd[g] ^ syn.invert),
            .hs_o       (hs[g]),
            .ls_o       (ls[g])
        );
    end

    assign hs_a_o = hs[0];
    assign ls_a_o = ls[0];
    assign hs_b_o = hs[1];
    assign ls_b_o = ls[1];

    initial begin
        assert (DEAD_CYC >= 1) else $error("DEAD_CYC must be at least 1");
    end

    p_reset_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flag_n_o && !hs && !ls));

    p_latch_gates_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_n_o && $past(!flag_n_o)) |-> (hs == '0 && ls == '0));

endmodule

// File: tb/hbridge_ctrl_bench.sv
`timescale 1ns/1ps
module hbridge_ctrl_bench;

    localparam int DEAD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic leg_a = 1'b1, leg_b = 1'b1, invert = 1'b0, halt = 1'b1, arm = 1'b0, wake = 1'b0;
    logic uv = 1'b0, ot = 1'b0, cool = 1'b1, sc = 1'b0;
    logic hs_a, ls_a, hs_b, ls_b, flag_n;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    hbridge_ctrl #(.DEAD_CYC(DEAD)) u_hbridge_ctrl (
        .clk(clk), .rst_n(rst_n),
        .leg_a_i(leg_a), .leg_b_i(leg_b), .invert_i(invert),
        .halt_i(halt), .arm_i(arm), .wake_i(wake),
        .uv_i(uv), .ot_i(ot), .cool_i(cool), .sc_i(sc),
        .hs_a_o(hs_a), .ls_a_o(ls_a), .hs_b_o(hs_b), .ls_b_o(ls_b),
        .flag_n_o(flag_n)
    );

    task automatic chk(input logic [4:0] exp, input string tag);
        logic [4:0] act;
        act = {hs_a, ls_a, hs_b, ls_b, flag_n};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {hs_a,ls_a,hs_b,ls_b,flag_n} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    function automatic logic [4:0] drv(input logic w, h, a, i, la, lb);
        logic d;
        d = w && !h && a;
        return {d && (la ^ i), d && !(la ^ i), d && (lb ^ i), d && !(lb ^ i), 1'b1};
    endfunction

    task automatic sc_pulse();
        sc = 1'b1;
        repeat (3) @(negedge clk);
        sc = 1'b0;
        settle();
    endtask

    task automatic gap_check(input logic to_val, input string tag);
        int off_n = 0;
        int both_n = 0;
        leg_a = to_val;
        for (int c = 0; c < 14; c++) begin
            @(negedge clk);
            if (!hs_a && !ls_a) off_n++;
            if (hs_a && ls_a) both_n++;
        end
        n_chk++;
        if (off_n != DEAD || both_n != 0) begin
            n_bad++;
            $display("FAIL %s: off cycles %0d overlap %0d expected off %0d overlap 0",
                     tag, off_n, both_n, DEAD);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(5'b00001, "R5 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(5'b00001, "R5 just after reset");
        settle();
        chk(5'b00001, "R5 idle inputs");

        // R1 R2 R3 R4: sweep all combinations of the six control inputs
        for (int k = 0; k < 64; k++) begin
            {wake, halt, arm, invert, leg_a, leg_b} = 6'(k);
            settle();
            chk(drv(wake, halt, arm, invert, leg_a, leg_b),
                $sformatf("R1 R2 R3 R4 sweep code %0d", k));
        end

        // R11: dead band in both directions
        wake = 1'b1; halt = 1'b0; arm = 1'b1; invert = 1'b0; leg_a = 1'b1; leg_b = 1'b0;
        settle();
        chk(5'b10011, "R1 drive A high B low");
        gap_check(1'b0, "R11 high to low handover");
        gap_check(1'b1, "R11 low to high handover");

        // R6: short-circuit latch
        sc_pulse();
        chk(5'b00000, "R6 latched after short");
        leg_a = 1'b0;
        settle();
        chk(5'b00000, "R6 leg command ignored while latched");
        // R7: wrong direction edge on halt, then clearing edge
        halt = 1'b1;
        settle();
        chk(5'b00000, "R7 halt rising does not clear");
        halt = 1'b0;
        settle();
        chk(5'b01011, "R7 halt falling clears");
        // R7: arm path
        sc_pulse();
        chk(5'b00000, "R6 latched again");
        arm = 1'b0;
        settle();
        chk(5'b00000, "R7 arm falling does not clear");
        arm = 1'b1;
        settle();
        chk(5'b01011, "R7 arm rising clears");
        // R8: wake toggle
        sc_pulse();
        wake = 1'b0;
        settle();
        chk(5'b00001, "R8 sleep clears latch");
        wake = 1'b1;
        settle();
        chk(5'b01011, "R8 resumes after wake");

        // R9: overtemperature with cool-down gating
        cool = 1'b0; ot = 1'b1;
        repeat (3) @(negedge clk);
        ot = 1'b0;
        settle();
        chk(5'b00000, "R9 overtemperature latched");
        halt = 1'b1; settle(); halt = 1'b0; settle();
        chk(5'b00000, "R9 edge while hot discarded");
        cool = 1'b1;
        settle();
        chk(5'b00000, "R9 cooling alone does not clear");
        halt = 1'b1; settle(); halt = 1'b0; settle();
        chk(5'b01011, "R9 edge while cool clears");

        // R10: undervoltage auto recovery
        leg_b = 1'b1; invert = 1'b1;
        settle();
        chk(5'b10011, "R2 inverted drive");
        uv = 1'b1;
        settle();
        chk(5'b00000, "R10 undervoltage off with flag low");
        uv = 1'b0;
        settle();
        chk(5'b10011, "R10 recovers without edge");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #2ms;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule